// File: doc/BRIEF.md
# Interrupt Latency Tracker

This block measures how long software takes to respond to an interrupt. A one-cycle pulse marks the moment a request is raised. From that cycle on, a shared latency counter counts clock cycles. Software has four acknowledge points. Each one copies the current count into its own 32-bit snapshot register. The snapshot carries a "fresh" flag and a "clobbered" flag, so software can see whether it missed an earlier value.

Acknowledge point 0 stands for the low-level handler. Acknowledge point 3 stands for the end of application processing, and it also halts the counter. Points 1 and 2 mark intermediate steps and only take a snapshot.

Three wrapping event counters keep statistics: total requests, requests that arrived while point 0 was still outstanding, and requests that arrived while point 3 was still outstanding. Two pending flags show which acknowledgements are still owed. Bus decoding and request generation are done elsewhere and drive this block through single-cycle strobes.

The latency timer is a two-state machine:
- `LS_IDLE`: the counter is held.
- `LS_RUN`: the counter counts.

Its transitions are:
- `LS_IDLE -> LS_RUN` on a request.
- `LS_RUN -> LS_RUN` on a request. The counter restarts.
- `LS_RUN -> LS_IDLE` on acknowledge 3 without a request in the same cycle.

Top module: `irq_latency_tracker`

## Requirements
- R1: A request pulse loads the latency count with 0 on the next edge. While running, the count then rises by one per clock. Setting bit n of `ack_wr` copies the count present in that cycle into `lat_value[n]`.
- R2: Any combination of the four `ack_wr` bits may be set in one cycle. Each selected snapshot receives the same count.
- R3: `ack_wr[3]` without a request moves the timer to idle. `lat_running` drops and the count is frozen at the value just captured. A request in the same cycle takes precedence and restarts the timer.
- R4: `ack_wr[1]` and `ack_wr[2]` change only their own snapshot and flags. They leave running state, count, pending flags and event counters unchanged.
- R5: A capture sets `lat_valid[n]`. If that flag was still set before the capture, `lat_ovw[n]` is also set. The new value is stored either way.
- R6: `clr_latch[n]` clears `lat_valid[n]` and `lat_ovw[n]` and leaves `lat_value[n]` unchanged. A capture in the same cycle is applied after the clear.
- R7: `rd_latch[n]` clears `lat_valid[n]` only, and `lat_value[n]` is unchanged. If a read and a capture happen together, the flag ends set and no overwrite is recorded.
- R8: `total_cnt` rises by one on every request and wraps from all ones to zero.
- R9: On a request, `miss0_cnt` rises if `wait_ack0` is set and `ack_wr[0]` is not set in that cycle. `miss3_cnt` follows the same rule with `wait_ack3` and `ack_wr[3]`.
- R10: `clr_total`, `clr_miss0` and `clr_miss3` each zero their own counter. `clr_all` zeroes all three. A clear wins over an increment in the same cycle.
- R11: A request sets `wait_ack0` and `wait_ack3`. `ack_wr[0]` clears `wait_ack0` and `ack_wr[3]` clears `wait_ack3`. A request wins over an acknowledge in the same cycle.
- R12: While `enable` is 0, every register returns to zero on the next edge, and `rst_n` low does the same asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; 0 holds all state at zero |
| req_pulse | input | 1 | Interrupt request generated (one cycle) |
| ack_wr | input | NUM_ACK | Acknowledge strobes, one per snapshot |
| clr_latch | input | NUM_ACK | Clear valid and overwrite flags per snapshot |
| rd_latch | input | NUM_ACK | Snapshot read strobes |
| clr_total | input | 1 | Zero the total request counter |
| clr_miss0 | input | 1 | Zero the missed point-0 counter |
| clr_miss3 | input | 1 | Zero the missed point-3 counter |
| clr_all | input | 1 | Zero all three event counters |
| lat_value | output | NUM_ACK x LAT_W | Snapshot registers |
| lat_valid | output | NUM_ACK | Snapshot holds an unread value |
| lat_ovw | output | NUM_ACK | Unread snapshot was replaced |
| lat_running | output | 1 | Latency timer is counting |
| wait_ack0 | output | 1 | Acknowledge 0 outstanding |
| wait_ack3 | output | 1 | Acknowledge 3 outstanding |
| total_cnt | output | EVT_W | Total requests |
| miss0_cnt | output | EVT_W | Requests that found acknowledge 0 outstanding |
| miss3_cnt | output | EVT_W | Requests that found acknowledge 3 outstanding |

## Verification
The properties assume that every strobe is a plain level sampled at one edge and that strobes may coincide freely. They expect the priorities to resolve each collision: request over acknowledge 3, clear over increment, and read or clear before capture. The stimulus therefore draws each strobe independently from a seeded `$urandom`, so that collisions of every kind occur. It also toggles `enable` off rarely and holds it off for single cycles, which keeps the flags-after-reset properties meaningful. The event counters are narrowed in the bench so that wrapping is reached.

// File: rtl/irqlat_pkg.sv
package irqlat_pkg;
    typedef enum logic [0:0] {
        LS_IDLE = 1'b0,
        LS_RUN  = 1'b1
    } lat_state_e;

    localparam int unsigned CNT_TOTAL = 0;
    localparam int unsigned CNT_MISS0 = 1;
    localparam int unsigned CNT_MISS3 = 2;
    localparam int unsigned NUM_EVT   = 3;
endpackage

// File: rtl/irqlat_timer.sv
module irqlat_timer
    import irqlat_pkg::*;
#(
    parameter int unsigned LAT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             req,
    input  logic             ack0,
    input  logic             ack3,
    output logic [LAT_W-1:0] lat_count,
    output logic             running,
    output logic             wait0,
    output logic             wait3
);
    lat_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state_q <= LS_IDLE;
        else if (!enable) state_q <= LS_IDLE;
        else              state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_IDLE: if (req) state_d = LS_RUN;
            LS_RUN: begin
                if (req)       state_d = LS_RUN;
                else if (ack3) state_d = LS_IDLE;
            end
            default: state_d = LS_IDLE;
        endcase
    end

    // counter and pending flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_count <= '0;
            wait0     <= 1'b0;
            wait3     <= 1'b0;
        end else if (!enable) begin
            lat_count <= '0;
            wait0     <= 1'b0;
            wait3     <= 1'b0;
        end else begin
            if (req)
                lat_count <= '0;
            else if (state_q == LS_RUN && !ack3)
                lat_count <= lat_count + 1'b1;
            if (req)       wait0 <= 1'b1;
            else if (ack0) wait0 <= 1'b0;
            if (req)       wait3 <= 1'b1;
            else if (ack3) wait3 <= 1'b0;
        end
    end

    assign running = (state_q == LS_RUN);
endmodule

// File: rtl/irqlat_latch_bank.sv
module irqlat_latch_bank #(
    parameter int unsigned NUM_ACK = 4,
    parameter int unsigned LAT_W   = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            enable,
    input  logic [LAT_W-1:0]                lat_count,
    input  logic [NUM_ACK-1:0]              cap,
    input  logic [NUM_ACK-1:0]              clr,
    input  logic [NUM_ACK-1:0]              rd,
    output logic [NUM_ACK-1:0][LAT_W-1:0]   value,
    output logic [NUM_ACK-1:0]              valid,
    output logic [NUM_ACK-1:0]              ovw
);
    for (genvar i = 0; i < NUM_ACK; i++) begin : g_slot
        logic v_pre, o_pre;
        // clear and read apply before a capture in the same cycle
        always_comb begin
            v_pre = valid[i] & ~clr[i] & ~rd[i];
            o_pre = ovw[i] & ~clr[i];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                value[i] <= '0;
                valid[i] <= 1'b0;
                ovw[i]   <= 1'b0;
            end else if (!enable) begin
                value[i] <= '0;
                valid[i] <= 1'b0;
                ovw[i]   <= 1'b0;
            end else if (cap[i]) begin
                value[i] <= lat_count;
                valid[i] <= 1'b1;
                ovw[i]   <= o_pre | v_pre;
            end else begin
                valid[i] <= v_pre;
                ovw[i]   <= o_pre;
            end
        end
    end
endmodule

// File: rtl/irqlat_evt_counters.sv
module irqlat_evt_counters
    import irqlat_pkg::*;
#(
    parameter int unsigned EVT_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           enable,
    input  logic [NUM_EVT-1:0]             inc,
    input  logic [NUM_EVT-1:0]             clr,
    output logic [NUM_EVT-1:0][EVT_W-1:0]  cnt
);
    for (genvar k = 0; k < NUM_EVT; k++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt[k] <= '0;
            else if (!enable)     cnt[k] <= '0;
            else if (clr[k])      cnt[k] <= '0;
            else if (inc[k])      cnt[k] <= cnt[k] + 1'b1;
        end
    end
endmodule

// File: rtl/irq_latency_tracker.sv
module irq_latency_tracker
    import irqlat_pkg::*;
#(
    parameter int unsigned NUM_ACK = 4,
    parameter int unsigned LAT_W   = 32,
    parameter int unsigned EVT_W   = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enable,
    input  logic                          req_pulse,
    input  logic [NUM_ACK-1:0]            ack_wr,
    input  logic [NUM_ACK-1:0]            clr_latch,
    input  logic [NUM_ACK-1:0]            rd_latch,
    input  logic                          clr_total,
    input  logic                          clr_miss0,
    input  logic                          clr_miss3,
    input  logic                          clr_all,
    output logic [NUM_ACK-1:0][LAT_W-1:0] lat_value,
    output logic [NUM_ACK-1:0]            lat_valid,
    output logic [NUM_ACK-1:0]            lat_ovw,
    output logic                          lat_running,
    output logic                          wait_ack0,
    output logic                          wait_ack3,
    output logic [EVT_W-1:0]              total_cnt,
    output logic [EVT_W-1:0]              miss0_cnt,
    output logic [EVT_W-1:0]              miss3_cnt
);
    localparam int unsigned LAST_ACK = NUM_ACK - 1;

    logic [LAT_W-1:0]                lat_count;
    logic [NUM_EVT-1:0]              evt_inc, evt_clr;
    logic [NUM_EVT-1:0][EVT_W-1:0]   evt_cnt;

    irqlat_timer #(.LAT_W(LAT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .req       (req_pulse),
        .ack0      (ack_wr[0]),
        .ack3      (ack_wr[LAST_ACK]),
        .lat_count (lat_count),
        .running   (lat_running),
        .wait0     (wait_ack0),
        .wait3     (wait_ack3)
    );

    irqlat_latch_bank #(.NUM_ACK(NUM_ACK), .LAT_W(LAT_W)) u_latches (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .lat_count (lat_count),
        .cap       (ack_wr),
        .clr       (clr_latch),
        .rd        (rd_latch),
        .value     (lat_value),
        .valid     (lat_valid),
        .ovw       (lat_ovw)
    );

    always_comb begin
        evt_inc[CNT_TOTAL] = req_pulse;
        evt_inc[CNT_MISS0] = req_pulse & wait_ack0 & ~ack_wr[0];
        evt_inc[CNT_MISS3] = req_pulse & wait_ack3 & ~ack_wr[LAST_ACK];
        evt_clr[CNT_TOTAL] = clr_total | clr_all;
        evt_clr[CNT_MISS0] = clr_miss0 | clr_all;
        evt_clr[CNT_MISS3] = clr_miss3 | clr_all;
    end

    irqlat_evt_counters #(.EVT_W(EVT_W)) u_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .inc    (evt_inc),
        .clr    (evt_clr),
        .cnt    (evt_cnt)
    );

    assign total_cnt = evt_cnt[CNT_TOTAL];
    assign miss0_cnt = evt_cnt[CNT_MISS0];
    assign miss3_cnt = evt_cnt[CNT_MISS3];
endmodule

// File: rtl/irqlat_checker.sv
module irqlat_checker #(
    parameter int unsigned NUM_ACK = 4,
    parameter int unsigned LAT_W   = 32,
    parameter int unsigned EVT_W   = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          enable,
    input logic                          req_pulse,
    input logic [NUM_ACK-1:0]            ack_wr,
    input logic [NUM_ACK-1:0]            clr_latch,
    input logic [NUM_ACK-1:0]            rd_latch,
    input logic                          clr_total,
    input logic                          clr_all,
    input logic [NUM_ACK-1:0][LAT_W-1:0] lat_value,
    input logic [NUM_ACK-1:0]            lat_valid,
    input logic [NUM_ACK-1:0]            lat_ovw,
    input logic                          lat_running,
    input logic                          wait_ack0,
    input logic                          wait_ack3,
    input logic [EVT_W-1:0]              total_cnt,
    input logic [LAT_W-1:0]              lat_count
);
    localparam int unsigned LAST_ACK = NUM_ACK - 1;

    AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        enable && req_pulse |=> lat_running && lat_count == '0); // R1

    AST_ACK3_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        enable && ack_wr[LAST_ACK] && !req_pulse |=> !lat_running && !wait_ack3); // R3

    AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        enable && req_pulse && !clr_total && !clr_all
        |=> total_cnt == $past(total_cnt) + 1'b1); // R8

    AST_WAIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        enable && req_pulse |=> wait_ack0 && wait_ack3); // R11

    AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !lat_running && lat_valid == '0 && lat_ovw == '0 && total_cnt == '0); // R12

    for (genvar i = 0; i < NUM_ACK; i++) begin : g_chk
        AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            enable && ack_wr[i] |=> lat_valid[i] && lat_value[i] == $past(lat_count)); // R5
        AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            enable && clr_latch[i] && !ack_wr[i] |=> !lat_valid[i] && !lat_ovw[i]); // R6
        AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            enable && rd_latch[i] && !ack_wr[i] |=> !lat_valid[i] && $stable(lat_value[i])); // R7
    end
endmodule

bind irq_latency_tracker irqlat_checker #(
    .NUM_ACK(NUM_ACK), .LAT_W(LAT_W), .EVT_W(EVT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .req_pulse(req_pulse),
    .ack_wr(ack_wr), .clr_latch(clr_latch), .rd_latch(rd_latch),
    .clr_total(clr_total), .clr_all(clr_all), .lat_value(lat_value),
    .lat_valid(lat_valid), .lat_ovw(lat_ovw), .lat_running(lat_running),
    .wait_ack0(wait_ack0), .wait_ack3(wait_ack3), .total_cnt(total_cnt),
    .lat_count(lat_count)
);

// File: tb/irq_latency_tracker_test.sv
module irq_latency_tracker_test;
    localparam int N  = 4;
    localparam int LW = 32;
    localparam int EW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic req_pulse = 1'b0;
    logic [N-1:0] ack_wr = '0, clr_latch = '0, rd_latch = '0;
    logic clr_total = 1'b0, clr_miss0 = 1'b0, clr_miss3 = 1'b0, clr_all = 1'b0;
    logic [N-1:0][LW-1:0] lat_value;
    logic [N-1:0] lat_valid, lat_ovw;
    logic lat_running, wait_ack0, wait_ack3;
    logic [EW-1:0] total_cnt, miss0_cnt, miss3_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference state
    logic [LW-1:0] m_cnt;
    logic m_run, m_w0, m_w3;
    logic [N-1:0][LW-1:0] m_lat;
    logic [N-1:0] m_v, m_o;
    logic [EW-1:0] m_tot, m_m0, m_m3;

    always #4 clk = ~clk;

    irq_latency_tracker #(.NUM_ACK(N), .LAT_W(LW), .EVT_W(EW)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .req_pulse(req_pulse),
        .ack_wr(ack_wr), .clr_latch(clr_latch), .rd_latch(rd_latch),
        .clr_total(clr_total), .clr_miss0(clr_miss0), .clr_miss3(clr_miss3),
        .clr_all(clr_all), .lat_value(lat_value), .lat_valid(lat_valid),
        .lat_ovw(lat_ovw), .lat_running(lat_running), .wait_ack0(wait_ack0),
        .wait_ack3(wait_ack3), .total_cnt(total_cnt), .miss0_cnt(miss0_cnt),
        .miss3_cnt(miss3_cnt)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cnt = '0; m_run = 1'b0; m_w0 = 1'b0; m_w3 = 1'b0;
        m_lat = '0; m_v = '0; m_o = '0;
        m_tot = '0; m_m0 = '0; m_m3 = '0;
    endtask

    task automatic model_update();
        logic vp, op, i0, i3;
        if (!enable) begin
            model_reset();
            return;
        end
        for (int i = 0; i < N; i++) begin
            vp = m_v[i] & ~clr_latch[i] & ~rd_latch[i];
            op = m_o[i] & ~clr_latch[i];
            if (ack_wr[i]) begin
                m_lat[i] = m_cnt; m_v[i] = 1'b1; m_o[i] = op | vp;
            end else begin
                m_v[i] = vp; m_o[i] = op;
            end
        end
        i0 = req_pulse & m_w0 & ~ack_wr[0];
        i3 = req_pulse & m_w3 & ~ack_wr[3];
        if (clr_total || clr_all) m_tot = '0; else if (req_pulse) m_tot = m_tot + 1'b1;
        if (clr_miss0 || clr_all) m_m0 = '0;  else if (i0) m_m0 = m_m0 + 1'b1;
        if (clr_miss3 || clr_all) m_m3 = '0;  else if (i3) m_m3 = m_m3 + 1'b1;
        if (req_pulse) begin
            m_cnt = '0; m_run = 1'b1;
        end else if (m_run) begin
            if (ack_wr[3]) m_run = 1'b0;
            else m_cnt = m_cnt + 1'b1;
        end
        if (req_pulse) begin m_w0 = 1'b1; m_w3 = 1'b1; end
        else begin
            if (ack_wr[0]) m_w0 = 1'b0;
            if (ack_wr[3]) m_w3 = 1'b0;
        end
    endtask

    task automatic compare_all();
        for (int i = 0; i < N; i++) chk("R1 snapshot value", lat_value[i], m_lat[i]);
        chk("R5 valid flags", lat_valid, m_v);
        chk("R5 overwrite flags", lat_ovw, m_o);
        chk("R3 running", lat_running, m_run);
        chk("R11 wait0", wait_ack0, m_w0);
        chk("R11 wait3", wait_ack3, m_w3);
        chk("R8 total", total_cnt, m_tot);
        chk("R9 miss0", miss0_cnt, m_m0);
        chk("R9 miss3", miss3_cnt, m_m3);
    endtask

    // one edge: inputs already driven, check after it, then drop pulses
    task automatic tick();
        @(posedge clk);
        #1;
        model_update();
        compare_all();
        @(negedge clk);
        req_pulse = 1'b0; ack_wr = '0; clr_latch = '0; rd_latch = '0;
        clr_total = 1'b0; clr_miss0 = 1'b0; clr_miss3 = 1'b0; clr_all = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        if (!done) begin
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state
        chk("R12 reset valid", lat_valid, '0);
        chk("R12 reset running", lat_running, 1'b0);
        chk("R12 reset total", total_cnt, '0);
        enable = 1'b1;
        tick();

        // R1: count 5 cycles after request, capture on point 1
        req_pulse = 1'b1; tick();
        repeat (5) tick();
        ack_wr = 4'b0010; tick();
        chk("R1 latency five", lat_value[1], 5);
        chk("R4 point1 keeps running", lat_running, 1'b1);
        chk("R4 point1 keeps wait0", wait_ack0, 1'b1);

        // R2: simultaneous capture on points 0 and 2
        ack_wr = 4'b0101; tick();
        chk("R2 point0", lat_value[0], 6);
        chk("R2 point2", lat_value[2], 6);
        chk("R11 wait0 cleared", wait_ack0, 1'b0);

        // R3: point 3 stops counting
        ack_wr = 4'b1000; tick();
        chk("R3 point3 value", lat_value[3], 7);
        chk("R3 stopped", lat_running, 1'b0);
        tick(); tick();
        ack_wr = 4'b0010; tick();
        chk("R3 frozen count", lat_value[1], 7);
        chk("R5 overwrite set", lat_ovw[1], 1'b1);

        // R7: read clears only valid
        rd_latch = 4'b0010; tick();
        chk("R7 valid cleared", lat_valid[1], 1'b0);
        chk("R7 value kept", lat_value[1], 7);
        chk("R7 ovw kept", lat_ovw[1], 1'b1);

        // R6: clear strobe
        clr_latch = 4'b0010; tick();
        chk("R6 ovw cleared", lat_ovw[1], 1'b0);
        chk("R6 value kept", lat_value[1], 7);

        // R9: back-to-back requests without acknowledge
        req_pulse = 1'b1; tick();
        chk("R9 no miss first", miss0_cnt, 0);
        req_pulse = 1'b1; tick();
        chk("R9 miss0 one", miss0_cnt, 1);
        chk("R9 miss3 one", miss3_cnt, 1);

        // R10: individual clear
        clr_miss0 = 1'b1; tick();
        chk("R10 miss0 zero", miss0_cnt, 0);
        chk("R10 miss3 kept", miss3_cnt, 1);

        // R8: wrap the narrowed total counter (now 3)
        for (int k = 0; k < 13; k++) begin req_pulse = 1'b1; tick(); end
        chk("R8 wrap", total_cnt, 0);

        // R10: clear all
        clr_all = 1'b1; req_pulse = 1'b1; tick();
        chk("R10 all total", total_cnt, 0);
        chk("R10 all miss3", miss3_cnt, 0);

        // R12: enable low
        enable = 1'b0; tick();
        chk("R12 disabled value", lat_value[0], 0);
        chk("R12 disabled wait3", wait_ack3, 1'b0);
        enable = 1'b1; tick();

        // constrained random traffic
        for (int c = 0; c < 6000; c++) begin
            enable    = ($urandom % 300) != 0;
            req_pulse = ($urandom % 14) == 0;
            for (int b = 0; b < N; b++) begin
                ack_wr[b]    = ($urandom % 9) == 0;
                clr_latch[b] = ($urandom % 30) == 0;
                rd_latch[b]  = ($urandom % 7) == 0;
            end
            clr_total = ($urandom % 60) == 0;
            clr_miss0 = ($urandom % 60) == 0;
            clr_miss3 = ($urandom % 60) == 0;
            clr_all   = ($urandom % 90) == 0;
            tick();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule